// File: doc/BRIEF.md
# Register-Programmed Word Copy Engine

This block moves a run of 32-bit words from one memory region to another with no help from a processor. Software sets it up over a zero-wait APB3 slave port: a source base address, a destination base address, a word count, and a control word. The control word holds a self-clearing start bit and an interrupt enable. The same port reads back a status word with busy, done and error flags.

Once started, the engine acts as an AXI4-Lite master. For each word it reads from the source side, then writes that value to the destination side, and it waits for the write response before it issues the next read. Only one bus transaction is in flight at any time. A response other than OKAY on either side ends the run with the error flag set. The interrupt line is level-sensitive. It stays high while the enable is set and the run has finished, whether it finished cleanly or with an error.

Top module: `wordmove_dma`

## Requirements
- R1: The APB port holds PREADY high. An access (PSEL and PENABLE both high) to any offset other than 0x00, 0x04, 0x08, 0x0C or 0x10 raises PSLVERR in that access cycle and changes no state.
- R2: Offset 0x00 (source base) and offset 0x04 (destination base) read back the value last written. Offset 0x08 (word count) keeps only the low LEN_W bits and reads zero above them.
- R3: At offset 0x0C, bit 1 is the interrupt enable and reads back as written. Bit 0 is the start command and always reads back as 0.
- R4: Offset 0x10 reads {29'b0, err, done, busy}, with busy in bit 0, done in bit 1 and err in bit 2. It is read-only: a write to it changes nothing and raises no PSLVERR. All three flags are 0 after reset.
- R5: Word i is read from source+4·i and then written to destination+4·i with the data just read, for i from 0 to count−1, in ascending order.
- R6: At most one AXI transaction is outstanding. No write starts before its read data has arrived, and no read starts before the previous write response has arrived.
- R7: Once ARVALID, AWVALID or WVALID is asserted, it stays high and its address or data stays stable until the matching ready is seen.
- R8: AWVALID and WVALID are raised in the same cycle for each word.
- R9: A read or write response other than OKAY (2'b00) sets err, clears busy, leaves done at 0 and ends the run. No further AXI request is issued, and a failed write is not retried.
- R10: A start command written while busy is ignored. The run in progress moves exactly its original count.
- R11: A start command with a word count of zero sets done at once and produces no AXI traffic.
- R12: An accepted start command clears done and err.
- R13: The irq output equals (done OR err) AND interrupt enable, in every cycle.
- R14: The write response for the last word clears busy and sets done on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | PA_W | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, held high |
| pslverr | output | 1 | APB error for unmapped offsets |
| m_awaddr | output | AW | AXI write address |
| m_awvalid | output | 1 | AXI write address valid |
| m_awready | input | 1 | AXI write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | AXI write strobes, all set |
| m_wvalid | output | 1 | AXI write data valid |
| m_wready | input | 1 | AXI write data ready |
| m_bresp | input | 2 | AXI write response |
| m_bvalid | input | 1 | AXI write response valid |
| m_bready | output | 1 | AXI write response ready |
| m_araddr | output | AW | AXI read address |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_rdata | input | 32 | AXI read data |
| m_rresp | input | 2 | AXI read response |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |
| irq | output | 1 | Completion or error interrupt, level |

## Verification
The bench builds the engine with PA_W=8 and AW=32, and with LEN_W narrowed to 6. The narrow count lets a single write with all upper bits set show the count field truncating and reading zero above bit 5. The 8-bit offset space reaches both an offset just past the map and a misaligned one. The responder staggers AWREADY and WREADY on different cycle phases, so the engine must cope with the two write channels completing apart. It injects SLVERR at a chosen read or write address to stop a run partway through.

// File: rtl/wordmove_pkg.sv
// Shared constants and types for the word copy engine.
// Assumes a 32-bit register and data word throughout.
package wordmove_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned STRB_W   = WORD_W / 8;
    localparam int unsigned WORD_B   = WORD_W / 8;

    localparam int unsigned OFF_SRC  = 'h00;
    localparam int unsigned OFF_DST  = 'h04;
    localparam int unsigned OFF_CNT  = 'h08;
    localparam int unsigned OFF_CTL  = 'h0C;
    localparam int unsigned OFF_STAT = 'h10;

    localparam int unsigned CTL_GO   = 0;
    localparam int unsigned CTL_IE   = 1;

    localparam logic [1:0]  RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        SEL_SRC,
        SEL_DST,
        SEL_CNT,
        SEL_CTL,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_RADDR,
        MV_RDATA,
        MV_WRITE,
        MV_WRESP
    } mv_state_e;

endpackage

// File: rtl/wordmove_apb_regs.sv
// APB3 register front end of the word copy engine.
// Decodes the five offsets, holds the programming registers and the
// busy/done/err/enable flags, and issues a one-cycle go pulse to the mover.
// Assumes the mover reports its finish through fin_ok or fin_err pulses.
module wordmove_apb_regs
    import wordmove_pkg::*;
#(
    parameter int unsigned PA_W  = 8,
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [PA_W-1:0]   paddr,
    input  logic [WORD_W-1:0] pwdata,
    output logic [WORD_W-1:0] prdata,
    output logic              pslverr,
    output logic [AW-1:0]     src_base,
    output logic [AW-1:0]     dst_base,
    output logic [LEN_W-1:0]  word_cnt,
    output logic              go,
    input  logic              fin_ok,
    input  logic              fin_err,
    output logic              irq
);

    reg_sel_e   sel;
    logic       acc;
    logic       wr;
    logic       start_ok;
    logic       busy_q, done_q, err_q, ie_q;

    // Map the offset onto a register selector.
    always_comb begin
        sel = SEL_NONE;
        if (paddr == PA_W'(OFF_SRC))       sel = SEL_SRC;
        else if (paddr == PA_W'(OFF_DST))  sel = SEL_DST;
        else if (paddr == PA_W'(OFF_CNT))  sel = SEL_CNT;
        else if (paddr == PA_W'(OFF_CTL))  sel = SEL_CTL;
        else if (paddr == PA_W'(OFF_STAT)) sel = SEL_STAT;
    end

    assign acc      = psel & penable;
    assign wr       = acc & pwrite;
    assign pslverr  = acc & (sel == SEL_NONE);
    assign start_ok = wr & (sel == SEL_CTL) & pwdata[CTL_GO] & ~busy_q;
    assign go       = start_ok & (word_cnt != '0);
    assign irq      = (done_q | err_q) & ie_q;

    // Hold the programming registers written over APB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            word_cnt <= '0;
            ie_q     <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_SRC: src_base <= pwdata[AW-1:0];
                SEL_DST: dst_base <= pwdata[AW-1:0];
                SEL_CNT: word_cnt <= pwdata[LEN_W-1:0];
                SEL_CTL: ie_q     <= pwdata[CTL_IE];
                default: ;
            endcase
        end
    end

    // Track run status: start, clean finish and error finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (start_ok) begin
            busy_q <= (word_cnt != '0);
            done_q <= (word_cnt == '0);
            err_q  <= 1'b0;
        end else if (fin_err) begin
            busy_q <= 1'b0;
            err_q  <= 1'b1;
        end else if (fin_ok) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end
    end

    // Return the selected register during a read access.
    always_comb begin
        prdata = '0;
        if (acc && !pwrite) begin
            case (sel)
                SEL_SRC:  prdata = WORD_W'(src_base);
                SEL_DST:  prdata = WORD_W'(dst_base);
                SEL_CNT:  prdata = WORD_W'(word_cnt);
                SEL_CTL:  prdata = WORD_W'({ie_q, 1'b0});
                SEL_STAT: prdata = WORD_W'({err_q, done_q, busy_q});
                default:  prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wordmove_mover.sv
// AXI4-Lite master side of the word copy engine.
// Runs one read then one write per word, with a single transaction in
// flight, and stops early on a non-OKAY response.
// Assumes go is only pulsed while idle and with a non-zero count.
module wordmove_mover
    import wordmove_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [AW-1:0]     src_base,
    input  logic [AW-1:0]     dst_base,
    input  logic [LEN_W-1:0]  word_cnt,
    output logic              fin_ok,
    output logic              fin_err,
    output logic [AW-1:0]     m_awaddr,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [WORD_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [AW-1:0]     m_araddr,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [WORD_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rvalid,
    output logic              m_rready
);

    localparam logic [AW-1:0] STEP = AW'(WORD_B);

    mv_state_e          state;
    logic [AW-1:0]      rd_ptr;
    logic [AW-1:0]      wr_ptr;
    logic [LEN_W-1:0]   left;
    logic [WORD_W-1:0]  hold;
    logic               aw_seen;
    logic               w_seen;
    logic               aw_now;
    logic               w_now;
    logic               r_fire;
    logic               b_fire;

    assign m_araddr  = rd_ptr;
    assign m_arvalid = (state == MV_RADDR);
    assign m_rready  = (state == MV_RDATA);
    assign m_awaddr  = wr_ptr;
    assign m_wdata   = hold;
    assign m_wstrb   = '1;
    assign m_awvalid = (state == MV_WRITE) & ~aw_seen;
    assign m_wvalid  = (state == MV_WRITE) & ~w_seen;
    assign m_bready  = (state == MV_WRESP);

    assign aw_now  = aw_seen | m_awready;
    assign w_now   = w_seen | m_wready;
    assign r_fire  = m_rready & m_rvalid;
    assign b_fire  = m_bready & m_bvalid;
    assign fin_err = (r_fire & (m_rresp != RESP_OKAY)) |
                     (b_fire & (m_bresp != RESP_OKAY));
    assign fin_ok  = b_fire & (m_bresp == RESP_OKAY) & (left == LEN_W'(1));

    // Step through read address, read data, write, write response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= MV_IDLE;
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            left    <= '0;
            hold    <= '0;
            aw_seen <= 1'b0;
            w_seen  <= 1'b0;
        end else begin
            case (state)
                MV_IDLE: begin
                    if (go) begin
                        rd_ptr <= src_base;
                        wr_ptr <= dst_base;
                        left   <= word_cnt;
                        state  <= MV_RADDR;
                    end
                end
                MV_RADDR: begin
                    if (m_arready) state <= MV_RDATA;
                end
                MV_RDATA: begin
                    if (m_rvalid) begin
                        if (m_rresp != RESP_OKAY) begin
                            state <= MV_IDLE;
                        end else begin
                            hold    <= m_rdata;
                            aw_seen <= 1'b0;
                            w_seen  <= 1'b0;
                            state   <= MV_WRITE;
                        end
                    end
                end
                MV_WRITE: begin
                    aw_seen <= aw_now;
                    w_seen  <= w_now;
                    if (aw_now && w_now) state <= MV_WRESP;
                end
                MV_WRESP: begin
                    if (m_bvalid) begin
                        if (m_bresp != RESP_OKAY || left == LEN_W'(1)) begin
                            state <= MV_IDLE;
                        end else begin
                            left   <= left - LEN_W'(1);
                            rd_ptr <= rd_ptr + STEP;
                            wr_ptr <= wr_ptr + STEP;
                            state  <= MV_RADDR;
                        end
                    end
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wordmove_dma.sv
// Top of the word copy engine: APB3 register front end plus AXI4-Lite
// mover. Assumes a single clock domain and synchronous active-low reset.
module wordmove_dma
    import wordmove_pkg::*;
#(
    parameter int unsigned PA_W  = 8,
    parameter int unsigned AW    = 32,
    parameter int unsigned LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [PA_W-1:0]   paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [AW-1:0]     m_awaddr,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [31:0]       m_wdata,
    output logic [3:0]        m_wstrb,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [AW-1:0]     m_araddr,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [31:0]       m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rvalid,
    output logic              m_rready,
    output logic              irq
);

    logic [AW-1:0]    src_base;
    logic [AW-1:0]    dst_base;
    logic [LEN_W-1:0] word_cnt;
    logic             go;
    logic             fin_ok;
    logic             fin_err;

    assign pready = 1'b1;

    wordmove_apb_regs #(
        .PA_W  (PA_W),
        .AW    (AW),
        .LEN_W (LEN_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pslverr  (pslverr),
        .src_base (src_base),
        .dst_base (dst_base),
        .word_cnt (word_cnt),
        .go       (go),
        .fin_ok   (fin_ok),
        .fin_err  (fin_err),
        .irq      (irq)
    );

    wordmove_mover #(
        .AW    (AW),
        .LEN_W (LEN_W)
    ) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .word_cnt  (word_cnt),
        .fin_ok    (fin_ok),
        .fin_err   (fin_err),
        .m_awaddr  (m_awaddr),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_bresp   (m_bresp),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_araddr  (m_araddr),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_rdata   (m_rdata),
        .m_rresp   (m_rresp),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready)
    );

endmodule

// File: rtl/wordmove_dma_chk.sv
// Protocol and behaviour checks for the word copy engine, bound to its top.
// Observes only the top-level ports.
module wordmove_dma_chk #(
    parameter int unsigned PA_W = 8,
    parameter int unsigned AW   = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            psel,
    input logic            penable,
    input logic            pwrite,
    input logic [PA_W-1:0] paddr,
    input logic [31:0]     pwdata,
    input logic            pslverr,
    input logic [AW-1:0]   m_awaddr,
    input logic            m_awvalid,
    input logic            m_awready,
    input logic [31:0]     m_wdata,
    input logic            m_wvalid,
    input logic            m_wready,
    input logic            m_bready,
    input logic [AW-1:0]   m_araddr,
    input logic            m_arvalid,
    input logic            m_arready,
    input logic [1:0]      m_rresp,
    input logic            m_rvalid,
    input logic            m_rready,
    input logic            irq
);

    // A misaligned offset is never in the map.
    p_misaligned_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && paddr[1:0] != 2'b00) |-> pslverr);

    // Read and write sides never overlap.
    p_single_txn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !((m_arvalid || m_rready) && (m_awvalid || m_wvalid || m_bready)));

    p_ar_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    p_aw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    p_w_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    p_aw_w_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> $rose(m_wvalid));

    p_rd_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rvalid && m_rready && m_rresp != 2'b00) |=>
        (!m_arvalid && !m_awvalid && !m_wvalid));

    // Clearing the enable silences the interrupt on the next cycle.
    p_irq_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr == PA_W'(12) && !pwdata[1]) |=> !irq);

endmodule

bind wordmove_dma wordmove_dma_chk #(.PA_W(PA_W), .AW(AW)) u_chk (.*);

// File: tb/wordmove_dma_tb.sv
// Bench for the word copy engine: behavioural reference model of the
// register flags and the expected AXI traffic, with a reactive memory.
module wordmove_dma_tb;

    localparam int PA_W  = 8;
    localparam int AW    = 32;
    localparam int LEN_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [PA_W-1:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready, pslverr;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready, irq;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0, m_rvalid = 0;
    logic [1:0] m_bresp = 0, m_rresp = 0;
    logic [31:0] m_rdata = '0;

    always #5 clk = ~clk;

    wordmove_dma #(.PA_W(PA_W), .AW(AW), .LEN_W(LEN_W)) u_dut (.*);

    int n_chk = 0;
    int n_err = 0;

    // Reference model state
    logic [31:0] mem [logic [31:0]];
    logic [31:0] src_m, dst_m, nxt_rd, nxt_wr, cur_src, aw_a, w_d;
    int   len_m, left_m, cyc, n_ar, n_wr;
    bit   busy_m, done_m, err_m, ie_m;
    bit   rd_pend, aw_got, w_got, b_pend, b_err;
    logic [31:0] rd_err_addr = 32'hFFFF_FFFF;
    logic [31:0] wr_err_addr = 32'hFFFF_FFFF;

    function automatic logic [31:0] memval(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return {a[15:0], ~a[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Model update at each edge from pre-edge port values.
    always @(posedge clk) begin
        if (!rst_n) begin
            src_m = 0; dst_m = 0; len_m = 0; left_m = 0; cyc = 0;
            busy_m = 0; done_m = 0; err_m = 0; ie_m = 0;
            rd_pend = 0; aw_got = 0; w_got = 0; b_pend = 0; b_err = 0;
        end else begin
            cyc++;
            if (psel && penable && pwrite) begin
                case (paddr)
                    8'h00: src_m = pwdata;
                    8'h04: dst_m = pwdata;
                    8'h08: len_m = int'(pwdata[LEN_W-1:0]);
                    8'h0C: begin
                        ie_m = pwdata[1];
                        if (pwdata[0] && !busy_m) begin
                            err_m = 0;
                            done_m = (len_m == 0);
                            busy_m = (len_m != 0);
                            nxt_rd = src_m; nxt_wr = dst_m; left_m = len_m;
                        end
                    end
                    default: ;
                endcase
            end
            if (m_arvalid && m_arready) begin
                n_ar++;
                chk("R5 read address", m_araddr, nxt_rd);
                cur_src = m_araddr;
                rd_pend = 1;
            end
            if (m_rvalid && m_rready) begin
                rd_pend = 0;
                if (m_rresp != 2'b00) begin err_m = 1; busy_m = 0; end
            end
            if (m_awvalid && m_awready) begin aw_got = 1; aw_a = m_awaddr; end
            if (m_wvalid && m_wready) begin w_got = 1; w_d = m_wdata; end
            if (aw_got && w_got && !b_pend) begin
                n_wr++;
                chk("R5 write address", aw_a, nxt_wr);
                chk("R5 write data", w_d, memval(cur_src));
                b_err = (aw_a == wr_err_addr);
                if (!b_err) mem[aw_a] = w_d;
                b_pend = 1; aw_got = 0; w_got = 0;
            end
            if (m_bvalid && m_bready) begin
                b_pend = 0;
                if (b_err) begin
                    err_m = 1; busy_m = 0;
                end else begin
                    left_m--; nxt_rd += 4; nxt_wr += 4;
                    if (left_m == 0) begin done_m = 1; busy_m = 0; end
                end
            end
        end
    end

    // Reactive memory drive and per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_arready = 0; m_rvalid = 0; m_awready = 0; m_wready = 0; m_bvalid = 0;
        end else begin
            chk("R13 irq level", {31'b0, irq}, {31'b0, (done_m | err_m) & ie_m});
            if (!busy_m)
                chk("R11 no request while idle", {29'b0, m_arvalid, m_awvalid, m_wvalid}, 0);
            m_arready = m_arvalid && !rd_pend && (cyc % 3 != 0);
            m_rvalid  = rd_pend && (m_rvalid || cyc[0]);
            m_rdata   = memval(cur_src);
            m_rresp   = (cur_src == rd_err_addr) ? 2'b10 : 2'b00;
            m_awready = m_awvalid && !aw_got && (cyc % 3 != 1);
            m_wready  = m_wvalid && !w_got && (cyc % 2 == 1);
            m_bvalid  = b_pend && (m_bvalid || (cyc % 2 == 0));
            m_bresp   = b_err ? 2'b10 : 2'b00;
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, output logic e);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1; #1 e = pslverr;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata; e = pslverr;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        logic e;
        st = 32'h1;
        for (int k = 0; k < 400 && st[0]; k++) apb_rd(8'h10, st, e);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R14 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic e;
        int ar0, wr0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R4 reset irq", {31'b0, irq}, 0);
        chk("R6 reset requests idle", {29'b0, m_arvalid, m_awvalid, m_wvalid}, 0);
        chk("R1 pready high", {31'b0, pready}, 1);
        apb_rd(8'h10, d, e); chk("R4 reset status", d, 0);
        apb_rd(8'h0C, d, e); chk("R3 reset control", d, 0);

        // R2 readback and count truncation
        apb_wr(8'h00, 32'h0000_1000, e);
        apb_wr(8'h04, 32'h0000_2000, e);
        apb_wr(8'h08, 32'hFFFF_FF45, e);
        apb_rd(8'h00, d, e); chk("R2 source readback", d, 32'h1000);
        apb_rd(8'h04, d, e); chk("R2 destination readback", d, 32'h2000);
        apb_rd(8'h08, d, e); chk("R2 count truncated", d, 32'h05);

        // R1 unmapped offsets
        apb_wr(8'h14, 32'h1, e); chk("R1 pslverr past map", {31'b0, e}, 1);
        apb_rd(8'h02, d, e);     chk("R1 pslverr misaligned", {31'b0, e}, 1);
        apb_rd(8'h00, d, e);     chk("R1 no pslverr mapped", {31'b0, e}, 0);
        chk("R1 bad write left source", d, 32'h1000);

        // R4 status read-only
        apb_wr(8'h10, 32'h7, e); chk("R4 status write no error", {31'b0, e}, 0);
        apb_rd(8'h10, d, e);     chk("R4 status unchanged", d, 0);

        // Five-word run, with a second start while busy (R10)
        ar0 = n_ar; wr0 = n_wr;
        apb_wr(8'h0C, 32'h3, e);
        apb_rd(8'h0C, d, e); chk("R3 start reads zero", d, 32'h2);
        apb_rd(8'h10, d, e); chk("R4 busy during run", d, 32'h1);
        apb_wr(8'h08, 32'h2, e);
        apb_wr(8'h0C, 32'h3, e);
        wait_idle(d);
        chk("R14 done after last word", d, 32'h2);
        chk("R10 original count moved", n_wr - wr0, 5);
        chk("R6 reads match writes", n_ar - ar0, 5);
        chk("R13 irq after done", {31'b0, irq}, 1);
        for (int i = 0; i < 5; i++)
            chk("R5 destination content", memval(32'h2000 + 4 * i), {16'h1000 + 16'(4 * i), ~(16'h1000 + 16'(4 * i))});

        // R11 zero-length start
        ar0 = n_ar;
        apb_wr(8'h08, 32'h0, e);
        apb_wr(8'h0C, 32'h3, e);
        apb_rd(8'h10, d, e); chk("R11 zero count done at once", d, 32'h2);
        repeat (10) @(negedge clk);
        chk("R11 zero count no traffic", n_ar - ar0, 0);

        // R9 read error on the third word
        rd_err_addr = 32'h3008;
        ar0 = n_ar; wr0 = n_wr;
        apb_wr(8'h00, 32'h3000, e);
        apb_wr(8'h04, 32'h4000, e);
        apb_wr(8'h08, 32'h4, e);
        apb_wr(8'h0C, 32'h3, e);
        wait_idle(d);
        chk("R9 read error status", d, 32'h4);
        chk("R9 read error writes", n_wr - wr0, 2);
        chk("R9 read error stops reads", n_ar - ar0, 3);
        chk("R13 irq after error", {31'b0, irq}, 1);
        rd_err_addr = 32'hFFFF_FFFF;

        // R12 new start clears flags
        apb_wr(8'h00, 32'h5000, e);
        apb_wr(8'h04, 32'h6000, e);
        apb_wr(8'h08, 32'h1, e);
        apb_wr(8'h0C, 32'h3, e);
        apb_rd(8'h10, d, e); chk("R12 done and err cleared", d & 32'h6, 0);
        wait_idle(d);
        chk("R12 clean finish after error", d, 32'h2);

        // R9 write error on the second word
        wr_err_addr = 32'h8004;
        ar0 = n_ar; wr0 = n_wr;
        apb_wr(8'h00, 32'h7000, e);
        apb_wr(8'h04, 32'h8000, e);
        apb_wr(8'h08, 32'h3, e);
        apb_wr(8'h0C, 32'h3, e);
        wait_idle(d);
        chk("R9 write error status", d, 32'h4);
        chk("R9 write error reads", n_ar - ar0, 2);
        chk("R9 write error writes", n_wr - wr0, 2);
        wr_err_addr = 32'hFFFF_FFFF;

        // R13 enable cleared
        apb_wr(8'h0C, 32'h0, e);
        chk("R13 irq off when disabled", {31'b0, irq}, 0);
        apb_wr(8'h08, 32'h2, e);
        apb_wr(8'h0C, 32'h1, e);
        wait_idle(d);
        chk("R14 done without enable", d, 32'h2);
        chk("R13 irq stays low", {31'b0, irq}, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule